// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit closes a counter-controlled loop in one operation. From one strobed request it produces the updated loop index, a branch decision, and the address where the fetch goes next. An execution stage presents the operation code, the current index, the limit, a step, the address of the next sequential instruction and a displacement on one cycle with `in_valid` high. The registered result appears on the following cycle.

There are three families of operation. The increment family adds one to the index and tests the result against the limit. The decrement family subtracts one and tests the result against zero, ignoring the limit. The stepped family adds a signed step and tests against the limit. For the stepped family, the direction of that test follows the sign of the step. All arithmetic is signed 32-bit and wraps without trapping.

The updated index is always produced, whether or not the branch is taken. The unit-step families use a short signed displacement and the stepped family a long one. A branch that is not taken continues at the next sequential address.

Top module: `loop_branch_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle where `in_valid` was high, and low otherwise.
- R2: While `in_valid` is low, `out_index`, `out_taken` and `out_target` keep their previous values whatever the other inputs do.
- R3: Mode code 0 writes `in_index + 1` to `out_index` and takes the branch when that result is less than or equal to `in_limit` (signed). `in_step` has no effect.
- R4: Mode code 1 writes `in_index + 1` to `out_index` and takes the branch when that result is strictly less than `in_limit` (signed). `in_step` has no effect.
- R5: Mode code 2 writes `in_index - 1` and takes the branch when the result is at least zero. Mode code 3 writes `in_index - 1` and takes the branch when the result is above zero. In both modes `in_limit` and `in_step` have no effect.
- R6: Mode code 4 writes `in_index + in_step`. When bit 31 of `in_step` is 0 it takes the branch if the result is at most `in_limit`; when that bit is 1 it takes the branch if the result is at least `in_limit` (signed).
- R7: Index arithmetic wraps modulo 2^32, and the test uses the wrapped value. For example, 0x7FFFFFFF + 1 gives 0x80000000, which is a negative number.
- R8: A taken branch in modes 0 to 3 targets `in_next_pc` plus `in_disp[7:0]` sign-extended to 32 bits; `in_disp[15:8]` is ignored.
- R9: A taken branch in mode 4 targets `in_next_pc` plus all 16 bits of `in_disp` sign-extended to 32 bits.
- R10: When the branch is not taken, `out_target` equals `in_next_pc`.
- R11: Mode codes 5, 6 and 7 are reserved. They pass `in_index` through unchanged and never take the branch.
- R12: After reset, `out_valid`, `out_taken`, `out_index` and `out_target` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 3 | Operation code (0..4, 5..7 reserved) |
| in_index | input | 32 | Current loop index |
| in_limit | input | 32 | Loop limit (modes 0, 1, 4) |
| in_step | input | 32 | Signed step (mode 4) |
| in_next_pc | input | 32 | Address of the next sequential instruction |
| in_disp | input | 16 | Branch displacement (low 8 bits in modes 0..3) |
| out_valid | output | 1 | Result valid |
| out_index | output | 32 | Updated index |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Next fetch address |

## Verification
The cases that are hardest to reach are the ones where the index sits exactly at the limit or beside it. They matter most at the two ends of the signed range, where the increment or step wraps and the comparison flips. A random index almost never lands there. The stimulus therefore builds every index as the limit plus a small offset from -3 to +3, for limits that include zero and both signed extremes. It crosses that with every mode code, with positive, zero and negative steps, and with displacements at both sign boundaries of each width.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;
  localparam int LB_MODE_W = 3;

  typedef enum logic [LB_MODE_W-1:0] {
    LB_INC_LE   = 3'd0,
    LB_INC_LT   = 3'd1,
    LB_DEC_GE   = 3'd2,
    LB_DEC_GT   = 3'd3,
    LB_ADD_STEP = 3'd4
  } lb_mode_e;
endpackage

// File: rtl/lbu_index_update.sv
module lbu_index_update
  import loop_branch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [LB_MODE_W-1:0] mode,
  input  logic [DATA_W-1:0]    index,
  input  logic [DATA_W-1:0]    step,
  output logic [DATA_W-1:0]    new_index
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  function automatic logic [DATA_W-1:0] next_index(
    input logic [LB_MODE_W-1:0] m,
    input logic [DATA_W-1:0]    idx,
    input logic [DATA_W-1:0]    stp
  );
    case (m)
      LB_INC_LE, LB_INC_LT: next_index = idx + ONE;
      LB_DEC_GE, LB_DEC_GT: next_index = idx - ONE;
      LB_ADD_STEP:          next_index = idx + stp;
      default:              next_index = idx;
    endcase
  endfunction

  assign new_index = next_index(mode, index, step);
endmodule

// File: rtl/lbu_decide.sv
module lbu_decide
  import loop_branch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [LB_MODE_W-1:0] mode,
  input  logic [DATA_W-1:0]    new_index,
  input  logic [DATA_W-1:0]    limit,
  input  logic                 step_neg,
  output logic                 taken
);
  function automatic logic branch_test(
    input logic [LB_MODE_W-1:0] m,
    input logic signed [DATA_W-1:0] v,
    input logic signed [DATA_W-1:0] lim,
    input logic neg
  );
    case (m)
      LB_INC_LE:   branch_test = (v <= lim);
      LB_INC_LT:   branch_test = (v <  lim);
      LB_DEC_GE:   branch_test = (v >= 0);
      LB_DEC_GT:   branch_test = (v >  0);
      LB_ADD_STEP: branch_test = neg ? (v >= lim) : (v <= lim);
      default:     branch_test = 1'b0;
    endcase
  endfunction

  assign taken = branch_test(mode, $signed(new_index), $signed(limit), step_neg);
endmodule

// File: rtl/lbu_target.sv
module lbu_target
  import loop_branch_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SHORT_DISP_W = 8,
  parameter int LONG_DISP_W  = 16
) (
  input  logic [LB_MODE_W-1:0]   mode,
  input  logic                   taken,
  input  logic [ADDR_W-1:0]      next_pc,
  input  logic [LONG_DISP_W-1:0] disp,
  output logic [ADDR_W-1:0]      target
);
  localparam int SHORT_PAD = ADDR_W - SHORT_DISP_W;
  localparam int LONG_PAD  = ADDR_W - LONG_DISP_W;

  function automatic logic [ADDR_W-1:0] widen_disp(
    input logic [LB_MODE_W-1:0]   m,
    input logic [LONG_DISP_W-1:0] d
  );
    if (m == LB_ADD_STEP)
      widen_disp = {{LONG_PAD{d[LONG_DISP_W-1]}}, d};
    else
      widen_disp = {{SHORT_PAD{d[SHORT_DISP_W-1]}}, d[SHORT_DISP_W-1:0]};
  endfunction

  logic [ADDR_W-1:0] branch_addr;
  assign branch_addr = next_pc + widen_disp(mode, disp);
  assign target      = taken ? branch_addr : next_pc;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import loop_branch_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 32,
  parameter int SHORT_DISP_W = 8,
  parameter int LONG_DISP_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LB_MODE_W-1:0]   in_mode,
  input  logic [DATA_W-1:0]      in_index,
  input  logic [DATA_W-1:0]      in_limit,
  input  logic [DATA_W-1:0]      in_step,
  input  logic [ADDR_W-1:0]      in_next_pc,
  input  logic [LONG_DISP_W-1:0] in_disp,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_index,
  output logic                   out_taken,
  output logic [ADDR_W-1:0]      out_target
);
  logic [DATA_W-1:0] upd_index;
  logic              branch_hit;
  logic [ADDR_W-1:0] fetch_addr;

  lbu_index_update #(.DATA_W(DATA_W)) u_upd (
    .mode      (in_mode),
    .index     (in_index),
    .step      (in_step),
    .new_index (upd_index)
  );

  lbu_decide #(.DATA_W(DATA_W)) u_dec (
    .mode      (in_mode),
    .new_index (upd_index),
    .limit     (in_limit),
    .step_neg  (in_step[DATA_W-1]),
    .taken     (branch_hit)
  );

  lbu_target #(
    .ADDR_W       (ADDR_W),
    .SHORT_DISP_W (SHORT_DISP_W),
    .LONG_DISP_W  (LONG_DISP_W)
  ) u_tgt (
    .mode    (in_mode),
    .taken   (branch_hit),
    .next_pc (in_next_pc),
    .disp    (in_disp),
    .target  (fetch_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_index  <= '0;
      out_taken  <= 1'b0;
      out_target <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_index  <= upd_index;
        out_taken  <= branch_hit;
        out_target <= fetch_addr;
      end
    end
  end
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker
  import loop_branch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [LB_MODE_W-1:0] in_mode,
  input logic [DATA_W-1:0]    in_index,
  input logic [ADDR_W-1:0]    in_next_pc,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    out_index,
  input logic                 out_taken,
  input logic [ADDR_W-1:0]    out_target
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic is_inc, is_dec, is_rsv;
  assign is_inc = (in_mode == LB_INC_LE) || (in_mode == LB_INC_LT);
  assign is_dec = (in_mode == LB_DEC_GE) || (in_mode == LB_DEC_GT);
  assign is_rsv = (in_mode > LB_ADD_STEP);

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_index) && $stable(out_taken) && $stable(out_target)));
  p_inc_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_inc) |=> out_index == $past(in_index) + ONE);
  p_dec_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_dec) |=> out_index == $past(in_index) - ONE);
  p_dec_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == LB_DEC_GT && in_index == ONE) |=> !out_taken);
  p_fallthrough_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_taken || out_target == $past(in_next_pc)));
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rsv) |=> (!out_taken && out_index == $past(in_index)));
endmodule

bind loop_branch_unit lbu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_mode    (in_mode),
  .in_index   (in_index),
  .in_next_pc (in_next_pc),
  .out_valid  (out_valid),
  .out_index  (out_index),
  .out_taken  (out_taken),
  .out_target (out_target)
);

// File: tb/loop_branch_unit_tb.sv
`timescale 1ns/1ps
module loop_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_mode;
  logic [31:0] in_index, in_limit, in_step, in_next_pc;
  logic [15:0] in_disp;
  logic        out_valid;
  logic [31:0] out_index;
  logic        out_taken;
  logic [31:0] out_target;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  loop_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_index(in_index), .in_limit(in_limit), .in_step(in_step),
    .in_next_pc(in_next_pc), .in_disp(in_disp), .out_valid(out_valid),
    .out_index(out_index), .out_taken(out_taken), .out_target(out_target)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (mode %0d idx %h lim %h step %h pc %h disp %h)",
               req, act, exp, in_mode, in_index, in_limit, in_step, in_next_pc, in_disp);
    end
  endtask

  function automatic longint wrap32(input longint v);
    longint w = v;
    if (w > 64'sd2147483647)  w -= 64'sd4294967296;
    if (w < -64'sd2147483648) w += 64'sd4294967296;
    return w;
  endfunction

  // Reference: R3..R11 computed in 64-bit signed arithmetic
  task automatic model(input int m, input logic [31:0] idx, lim, stp, pc,
                       input logic [15:0] d,
                       output logic [31:0] e_idx, output logic e_tk,
                       output logic [31:0] e_tg);
    longint si, sl, ss, w, dv, t;
    si = longint'($signed(idx));
    sl = longint'($signed(lim));
    ss = longint'($signed(stp));
    case (m)
      0, 1: w = wrap32(si + 1);
      2, 3: w = wrap32(si - 1);
      4:    w = wrap32(si + ss);
      default: w = si;
    endcase
    case (m)
      0: e_tk = (w <= sl);
      1: e_tk = (w <  sl);
      2: e_tk = (w >= 0);
      3: e_tk = (w >  0);
      4: e_tk = (ss < 0) ? (w >= sl) : (w <= sl);
      default: e_tk = 1'b0;
    endcase
    e_idx = w[31:0];
    if (m == 4) dv = longint'($signed(d));
    else        dv = longint'($signed(d[7:0]));
    t = longint'({32'b0, pc}) + dv;
    e_tg = e_tk ? t[31:0] : pc;
  endtask

  task automatic do_op(input int m, input logic [31:0] idx, lim, stp, pc,
                       input logic [15:0] d);
    logic [31:0] e_idx, e_tg;
    logic e_tk;
    model(m, idx, lim, stp, pc, d, e_idx, e_tk, e_tg);
    in_valid = 1'b1; in_mode = m[2:0]; in_index = idx; in_limit = lim;
    in_step = stp; in_next_pc = pc; in_disp = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 out_valid", {31'b0, out_valid}, 32'd1);
    chk(m > 4 ? "R11 index" : (m == 4 ? "R6/R7 index" : "R3/R4/R5/R7 index"), out_index, e_idx);
    chk(m > 4 ? "R11 taken" : "R3/R4/R5/R6 taken", {31'b0, out_taken}, {31'b0, e_tk});
    chk(e_tk ? (m == 4 ? "R9 target" : "R8 target") : "R10 target", out_target, e_tg);
    // idle cycle with disturbed inputs: R2 hold
    in_mode = 3'(m + 1); in_index = ~idx; in_limit = ~lim; in_step = ~stp;
    in_next_pc = ~pc; in_disp = ~d;
    @(negedge clk);
    chk("R1 idle", {31'b0, out_valid}, 32'd0);
    chk("R2 hold", out_index ^ out_target, e_idx ^ e_tg);
    chk("R2 hold taken", {31'b0, out_taken}, {31'b0, e_tk});
  endtask

  initial begin
    logic [31:0] limits [5] = '{32'd0, 32'd5, 32'hFFFFFFFB, 32'h7FFFFFFF, 32'h80000000};
    logic [31:0] steps  [5] = '{32'd1, 32'd2, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'd0};
    logic [15:0] disps  [6] = '{16'h007F, 16'h0080, 16'h7FFF, 16'h8000, 16'hFF80, 16'h1203};
    logic [31:0] pcs    [3] = '{32'h0000_1000, 32'hFFFF_FFF0, 32'h0000_0010};
    int n = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_index = '0; in_limit = '0;
    in_step = '0; in_next_pc = '0; in_disp = '0;
    repeat (3) @(negedge clk);
    chk("R12 valid", {31'b0, out_valid}, 32'd0);
    chk("R12 index", out_index, 32'd0);
    chk("R12 taken", {31'b0, out_taken}, 32'd0);
    chk("R12 target", out_target, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int li = 0; li < 5; li++)
        for (int off = -3; off <= 3; off++)
          for (int si = 0; si < 5; si++) begin
            do_op(m, limits[li] + 32'(off), limits[li], steps[si],
                  pcs[n % 3], disps[n % 6]);
            n++;
          end
    // directed: R7 wrap at top, R5 decrement through zero
    do_op(0, 32'h7FFFFFFF, 32'h0, 32'd0, 32'h100, 16'hFF00);
    do_op(3, 32'd1, 32'd99, 32'd0, 32'h200, 16'h0004);
    do_op(2, 32'd0, 32'd99, 32'd0, 32'h200, 16'h0004);
    do_op(4, 32'h80000000, 32'h7FFFFFF0, 32'hFFFFFFFF, 32'h300, 16'h8001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule